// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block sequences the state changes a 32-bit processor with branch delay slots makes when it takes an exception and when it later leaves the handler. The pipeline presents a one-cycle request with an exception code, the PC of the faulting instruction, a flag saying whether that instruction sat in a delay slot, and the live status register. On the following clock edge the block updates its saved-PC and saved-status registers, produces the status value the core must adopt, and emits a one-cycle redirect pulse carrying the handler address.

A return request restores the status word from the saved copy, forces the always-one status bit, and redirects fetch to the saved PC. A debug-trap code does not vector at all: it raises a halt pulse toward the debug port carrying the trap PC. Codes the block does not recognise raise an error pulse and touch nothing else. Flushing the pipeline and the handler code are outside the block.

The saved PC differs by exception class: classes that complete the instruction save the address after it, classes that retry it save the instruction itself, and both step back one instruction when the fault hit a delay slot so the branch is replayed.

Top module: `exc_seq_ctrl`

## Requirements
- R1: For system-call (code 12) and floating-point (code 13) exceptions, `epc_q` becomes `exc_pc` + 4, or `exc_pc` when `exc_in_dslot` is 1, modulo 2^32.
- R2: For bus-error (code 2), alignment (code 6), illegal-instruction (code 7) and range (code 11) exceptions, `epc_q` becomes `exc_pc`, or `exc_pc` - 4 modulo 2^32 when `exc_in_dslot` is 1.
- R3: A reset exception (code 1) leaves `epc_q` unchanged while still saving the status word and vectoring like any other entry.
- R4: On every vectoring entry (codes 1, 2, 6, 7, 11, 12, 13), `esr_q` takes `sr_cur`, `sr_wr` pulses, and `sr_next` equals `sr_cur` with bit 13 (delay-slot-exception flag) replaced by `exc_in_dslot`.
- R5: The entry redirect address is the exception code shifted left by 8, plus 0xF000_0000 when bit 14 (high-vector select) of `sr_cur` is 1.
- R6: A trap (code 14) pulses `halt_req` with `halt_pc` equal to `exc_pc`; it produces no redirect, no status write, and leaves `epc_q` and `esr_q` unchanged.
- R7: A return request pulses `redir_vld` with `redir_pc` equal to `epc_q`, and pulses `sr_wr` with `sr_next` equal to `esr_q` with bit 15 (fixed-one flag) forced to 1.
- R8: `dslot_clear` pulses together with every vectoring entry and every return, and stays 0 for traps and unrecognised codes.
- R9: Any other code pulses `bad_code` and causes no redirect, no halt, no status write, and no change of `epc_q` or `esr_q`.
- R10: Each request takes effect at the next rising clock edge; the pulse outputs are high for exactly the one cycle after it, at most one of `redir_vld`, `halt_req`, `bad_code` is high, and an exception request wins over a simultaneous return request.
- R11: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req | input | 1 | One-cycle exception request |
| exc_code | input | CODE_W | Exception code |
| exc_pc | input | XLEN | PC of the faulting instruction |
| exc_in_dslot | input | 1 | Faulting instruction sat in a delay slot |
| sr_cur | input | XLEN | Live status register |
| rfe_req | input | 1 | One-cycle return-from-exception request |
| epc_q | output | XLEN | Saved exception PC |
| esr_q | output | XLEN | Saved status register |
| sr_next | output | XLEN | Status value the core must adopt when `sr_wr` is high |
| sr_wr | output | 1 | Status write pulse |
| redir_vld | output | 1 | Fetch redirect pulse |
| redir_pc | output | XLEN | Fetch redirect target |
| halt_req | output | 1 | Debug halt pulse on trap |
| halt_pc | output | XLEN | PC reported with the halt |
| bad_code | output | 1 | Unrecognised exception code pulse |
| dslot_clear | output | 1 | Cancel pending delay-slot state |

## Verification
The bench builds the block with its defaults, a 32-bit datapath and a 5-bit code, so all 32 codes can be swept against both delay-slot settings and both vector bases, reaching every class, the unassigned codes between them and both address regions. Each entry is followed by a return so the saved PC and status round-trip through the outputs. Wrap-around of the PC correction at address 0 and at the top of the address space, and an exception colliding with a return, are driven as separate cases.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

   typedef enum logic [2:0] {
      CL_BAD  = 3'd0,
      CL_RST  = 3'd1,
      CL_NEXT = 3'd2,
      CL_SAME = 3'd3,
      CL_TRAP = 3'd4
   } exc_class_e;

   localparam logic [7:0] EC_RESET   = 8'd1;
   localparam logic [7:0] EC_BUS     = 8'd2;
   localparam logic [7:0] EC_ALIGN   = 8'd6;
   localparam logic [7:0] EC_ILLEGAL = 8'd7;
   localparam logic [7:0] EC_RANGE   = 8'd11;
   localparam logic [7:0] EC_SYSCALL = 8'd12;
   localparam logic [7:0] EC_FPU     = 8'd13;
   localparam logic [7:0] EC_TRAP    = 8'd14;

   function automatic exc_class_e classify(input logic [7:0] c);
      exc_class_e r;
      case (c)
         EC_RESET:                              r = CL_RST;
         EC_SYSCALL, EC_FPU:                    r = CL_NEXT;
         EC_BUS, EC_ALIGN, EC_ILLEGAL, EC_RANGE: r = CL_SAME;
         EC_TRAP:                               r = CL_TRAP;
         default:                               r = CL_BAD;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/exc_classify.sv
module exc_classify
   import exc_seq_pkg::*;
#(
   parameter int unsigned CODE_W = 5
) (
   input  logic [CODE_W-1:0] code,
   output exc_class_e        cls
);
   logic [7:0] code8;

   always_comb begin
      code8 = 8'(code);
      cls   = classify(code8);
   end
endmodule

// File: rtl/exc_epc_calc.sv
module exc_epc_calc
   import exc_seq_pkg::*;
#(
   parameter int unsigned XLEN       = 32,
   parameter int unsigned INSN_BYTES = 4
) (
   input  exc_class_e      cls,
   input  logic [XLEN-1:0] pc,
   input  logic            in_dslot,
   output logic [XLEN-1:0] epc_new,
   output logic            epc_wr
);
   localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

   logic [XLEN-1:0] base;

   always_comb begin
      base   = in_dslot ? (pc - STEP) : pc;
      epc_wr = 1'b0;
      epc_new = base;
      case (cls)
         CL_NEXT: begin
            epc_new = base + STEP;
            epc_wr  = 1'b1;
         end
         CL_SAME: begin
            epc_new = base;
            epc_wr  = 1'b1;
         end
         default: begin
            epc_new = base;
            epc_wr  = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen #(
   parameter int unsigned     XLEN      = 32,
   parameter int unsigned     CODE_W    = 5,
   parameter int unsigned     VEC_SHIFT = 8,
   parameter logic [XLEN-1:0] HI_BASE   = 32'hF000_0000
) (
   input  logic [CODE_W-1:0] code,
   input  logic              hi_sel,
   output logic [XLEN-1:0]   target
);
   localparam int unsigned OFS_W = CODE_W + VEC_SHIFT;
   localparam logic [OFS_W-1:0] LOW_MASK = '1;
   localparam bit BASE_DISJOINT = ((HI_BASE & XLEN'(LOW_MASK)) == '0);

   logic [XLEN-1:0] offset;
   logic [XLEN-1:0] base;

   always_comb begin
      offset = {{(XLEN - OFS_W){1'b0}}, code, {VEC_SHIFT{1'b0}}};
      base   = hi_sel ? HI_BASE : '0;
   end

   generate
      if (BASE_DISJOINT) begin : g_or
         always_comb target = base | offset;
      end else begin : g_add
         always_comb target = base + offset;
      end
   endgenerate
endmodule

// File: rtl/exc_seq_ctrl.sv
module exc_seq_ctrl
   import exc_seq_pkg::*;
#(
   parameter int unsigned     XLEN       = 32,
   parameter int unsigned     CODE_W     = 5,
   parameter int unsigned     VEC_SHIFT  = 8,
   parameter int unsigned     INSN_BYTES = 4,
   parameter int unsigned     DSX_BIT    = 13,
   parameter int unsigned     HV_BIT     = 14,
   parameter int unsigned     FO_BIT     = 15,
   parameter logic [XLEN-1:0] HI_BASE    = 32'hF000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              exc_req,
   input  logic [CODE_W-1:0] exc_code,
   input  logic [XLEN-1:0]   exc_pc,
   input  logic              exc_in_dslot,
   input  logic [XLEN-1:0]   sr_cur,
   input  logic              rfe_req,
   output logic [XLEN-1:0]   epc_q,
   output logic [XLEN-1:0]   esr_q,
   output logic [XLEN-1:0]   sr_next,
   output logic              sr_wr,
   output logic              redir_vld,
   output logic [XLEN-1:0]   redir_pc,
   output logic              halt_req,
   output logic [XLEN-1:0]   halt_pc,
   output logic              bad_code,
   output logic              dslot_clear
);
   localparam logic [XLEN-1:0] FO_MASK = XLEN'(1) << FO_BIT;

   // elaboration-time parameter checks
   generate
      if (CODE_W < 4 || CODE_W > 8) begin : g_chk_code
         $error("CODE_W must lie in 4..8 to hold every exception code");
      end
      if (CODE_W + VEC_SHIFT >= XLEN) begin : g_chk_vec
         $error("vector offset does not fit below XLEN");
      end
      if (DSX_BIT >= XLEN || HV_BIT >= XLEN || FO_BIT >= XLEN) begin : g_chk_bits
         $error("status bit position outside XLEN");
      end
      if (DSX_BIT == HV_BIT || DSX_BIT == FO_BIT || HV_BIT == FO_BIT) begin : g_chk_uniq
         $error("status bit positions must be distinct");
      end
      if (INSN_BYTES == 0) begin : g_chk_step
         $error("INSN_BYTES must be non-zero");
      end
   endgenerate

   exc_class_e      cls;
   logic [XLEN-1:0] epc_new;
   logic            epc_wr;
   logic [XLEN-1:0] vec_pc;
   logic [XLEN-1:0] sr_entry;

   exc_classify #(.CODE_W(CODE_W)) u_cls (
      .code (exc_code),
      .cls  (cls)
   );

   exc_epc_calc #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_epc (
      .cls      (cls),
      .pc       (exc_pc),
      .in_dslot (exc_in_dslot),
      .epc_new  (epc_new),
      .epc_wr   (epc_wr)
   );

   exc_vector_gen #(
      .XLEN      (XLEN),
      .CODE_W    (CODE_W),
      .VEC_SHIFT (VEC_SHIFT),
      .HI_BASE   (HI_BASE)
   ) u_vec (
      .code   (exc_code),
      .hi_sel (sr_cur[HV_BIT]),
      .target (vec_pc)
   );

   always_comb begin
      sr_entry          = sr_cur;
      sr_entry[DSX_BIT] = exc_in_dslot;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         epc_q       <= '0;
         esr_q       <= '0;
         sr_next     <= '0;
         sr_wr       <= 1'b0;
         redir_vld   <= 1'b0;
         redir_pc    <= '0;
         halt_req    <= 1'b0;
         halt_pc     <= '0;
         bad_code    <= 1'b0;
         dslot_clear <= 1'b0;
      end else begin
         sr_wr       <= 1'b0;
         redir_vld   <= 1'b0;
         halt_req    <= 1'b0;
         bad_code    <= 1'b0;
         dslot_clear <= 1'b0;
         if (exc_req) begin
            case (cls)
               CL_TRAP: begin
                  halt_req <= 1'b1;
                  halt_pc  <= exc_pc;
               end
               CL_BAD: begin
                  bad_code <= 1'b1;
               end
               default: begin
                  if (epc_wr) epc_q <= epc_new;
                  esr_q       <= sr_cur;
                  sr_next     <= sr_entry;
                  sr_wr       <= 1'b1;
                  redir_vld   <= 1'b1;
                  redir_pc    <= vec_pc;
                  dslot_clear <= 1'b1;
               end
            endcase
         end else if (rfe_req) begin
            sr_next     <= esr_q | FO_MASK;
            sr_wr       <= 1'b1;
            redir_vld   <= 1'b1;
            redir_pc    <= epc_q;
            dslot_clear <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/exc_seq_ctrl_chk.sv
module exc_seq_ctrl_chk
   import exc_seq_pkg::*;
#(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned CODE_W  = 5,
   parameter int unsigned DSX_BIT = 13,
   parameter int unsigned FO_BIT  = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic              exc_req,
   input logic [CODE_W-1:0] exc_code,
   input logic [XLEN-1:0]   exc_pc,
   input logic              exc_in_dslot,
   input logic [XLEN-1:0]   sr_cur,
   input logic              rfe_req,
   input logic [XLEN-1:0]   epc_q,
   input logic [XLEN-1:0]   esr_q,
   input logic [XLEN-1:0]   sr_next,
   input logic              sr_wr,
   input logic              redir_vld,
   input logic [XLEN-1:0]   redir_pc,
   input logic              halt_req,
   input logic [XLEN-1:0]   halt_pc,
   input logic              bad_code,
   input logic              dslot_clear
);
   logic [7:0] c8;
   logic       is_next, is_same, is_rst, is_trap, is_vec;

   always_comb begin
      c8      = 8'(exc_code);
      is_next = (c8 == EC_SYSCALL) || (c8 == EC_FPU);
      is_same = (c8 == EC_BUS) || (c8 == EC_ALIGN) || (c8 == EC_ILLEGAL) || (c8 == EC_RANGE);
      is_rst  = (c8 == EC_RESET);
      is_trap = (c8 == EC_TRAP);
      is_vec  = is_next || is_same || is_rst;
   end

   assert_epc_after_R1: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req && is_next |=> epc_q == $past(exc_pc) + ($past(exc_in_dslot) ? XLEN'(0) : XLEN'(4)));

   assert_epc_at_R2: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req && is_same |=> epc_q == $past(exc_pc) - ($past(exc_in_dslot) ? XLEN'(4) : XLEN'(0)));

   assert_reset_keeps_epc_R3: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req && is_rst |=> $stable(epc_q) && redir_vld);

   assert_status_save_R4: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req && is_vec |=> esr_q == $past(sr_cur) && sr_wr && sr_next[DSX_BIT] == $past(exc_in_dslot));

   assert_trap_halts_R6: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req && is_trap |=> halt_req && halt_pc == $past(exc_pc) && !redir_vld && !sr_wr
                             && $stable(epc_q) && $stable(esr_q));

   assert_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rfe_req && !exc_req |=> redir_vld && redir_pc == $past(epc_q) && sr_wr && sr_next[FO_BIT]);

   assert_dslot_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_req && !is_vec) |=> !dslot_clear);

   assert_bad_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req && !is_vec && !is_trap |=> bad_code && !redir_vld && !halt_req && !sr_wr
                                         && $stable(epc_q) && $stable(esr_q));

   assert_one_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({redir_vld, halt_req, bad_code}) <= 1);

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !exc_req && !rfe_req |=> !redir_vld && !halt_req && !bad_code && !sr_wr && !dslot_clear);
endmodule

bind exc_seq_ctrl exc_seq_ctrl_chk #(
   .XLEN    (XLEN),
   .CODE_W  (CODE_W),
   .DSX_BIT (DSX_BIT),
   .FO_BIT  (FO_BIT)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .exc_req      (exc_req),
   .exc_code     (exc_code),
   .exc_pc       (exc_pc),
   .exc_in_dslot (exc_in_dslot),
   .sr_cur       (sr_cur),
   .rfe_req      (rfe_req),
   .epc_q        (epc_q),
   .esr_q        (esr_q),
   .sr_next      (sr_next),
   .sr_wr        (sr_wr),
   .redir_vld    (redir_vld),
   .redir_pc     (redir_pc),
   .halt_req     (halt_req),
   .halt_pc      (halt_pc),
   .bad_code     (bad_code),
   .dslot_clear  (dslot_clear)
);

// File: tb/exc_seq_ctrl_test.sv
module exc_seq_ctrl_test;
   localparam int XLEN   = 32;
   localparam int CODE_W = 5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              exc_req = 1'b0;
   logic [CODE_W-1:0] exc_code = '0;
   logic [XLEN-1:0]   exc_pc = '0;
   logic              exc_in_dslot = 1'b0;
   logic [XLEN-1:0]   sr_cur = '0;
   logic              rfe_req = 1'b0;
   logic [XLEN-1:0]   epc_q, esr_q, sr_next, redir_pc, halt_pc;
   logic              sr_wr, redir_vld, halt_req, bad_code, dslot_clear;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // bench model state
   logic [XLEN-1:0] m_epc = '0;
   logic [XLEN-1:0] m_esr = '0;

   always #5 clk = ~clk;

   exc_seq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_code(exc_code),
      .exc_pc(exc_pc), .exc_in_dslot(exc_in_dslot), .sr_cur(sr_cur),
      .rfe_req(rfe_req), .epc_q(epc_q), .esr_q(esr_q), .sr_next(sr_next),
      .sr_wr(sr_wr), .redir_vld(redir_vld), .redir_pc(redir_pc),
      .halt_req(halt_req), .halt_pc(halt_pc), .bad_code(bad_code),
      .dslot_clear(dslot_clear)
   );

   task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // drive one request at a falling edge, check one falling edge later
   task automatic apply(input bit ex, input bit rf, input int code,
                        input logic [XLEN-1:0] pc, input bit ds, input logic [XLEN-1:0] sr);
      logic [XLEN-1:0] e_redir_pc, e_sr_next, e_halt_pc;
      bit e_redir, e_halt, e_bad, e_wr;
      e_redir = 0; e_halt = 0; e_bad = 0; e_wr = 0;
      e_redir_pc = '0; e_sr_next = '0; e_halt_pc = '0;
      exc_req = ex; rfe_req = rf; exc_code = CODE_W'(code);
      exc_pc = pc; exc_in_dslot = ds; sr_cur = sr;
      if (ex) begin
         case (code)
            14: begin e_halt = 1; e_halt_pc = pc; end
            1, 2, 6, 7, 11, 12, 13: begin
               if (code == 12 || code == 13) m_epc = ds ? pc : pc + 32'd4;          // R1
               else if (code != 1)           m_epc = ds ? pc - 32'd4 : pc;          // R2, R3 keeps
               m_esr = sr;                                                          // R4
               e_wr = 1; e_sr_next = sr; e_sr_next[13] = ds;
               e_redir = 1;
               e_redir_pc = (32'(code) << 8) + (sr[14] ? 32'hF000_0000 : 32'h0);    // R5
            end
            default: e_bad = 1;                                                     // R9
         endcase
      end else if (rf) begin                                                        // R7
         e_wr = 1; e_sr_next = m_esr | 32'h0000_8000;
         e_redir = 1; e_redir_pc = m_epc;
      end
      @(negedge clk);
      exc_req = 0; rfe_req = 0;
      chk($sformatf("R1/R2/R3 epc code=%0d ds=%0d", code, ds), epc_q, m_epc);
      chk($sformatf("R4 esr code=%0d", code), esr_q, m_esr);
      chk($sformatf("R10 redir_vld code=%0d rfe=%0d", code, rf), 32'(redir_vld), 32'(e_redir));
      chk($sformatf("R6 halt_req code=%0d", code), 32'(halt_req), 32'(e_halt));
      chk($sformatf("R9 bad_code code=%0d", code), 32'(bad_code), 32'(e_bad));
      chk($sformatf("R4 sr_wr code=%0d", code), 32'(sr_wr), 32'(e_wr));
      chk($sformatf("R8 dslot_clear code=%0d", code), 32'(dslot_clear), 32'(e_redir));
      if (e_redir) chk($sformatf("R5/R7 redir_pc code=%0d rfe=%0d", code, rf), redir_pc, e_redir_pc);
      if (e_wr)    chk($sformatf("R4/R7 sr_next code=%0d", code), sr_next, e_sr_next);
      if (e_halt)  chk("R6 halt_pc", halt_pc, e_halt_pc);
   endtask

   task automatic idle_check;
      @(negedge clk);
      chk("R10 pulses drop", 32'({redir_vld, halt_req, bad_code, sr_wr, dslot_clear}), 32'd0);
   endtask

   initial begin
      repeat (2) @(negedge clk);
      // R11: reset state
      chk("R11 epc", epc_q, '0);
      chk("R11 esr", esr_q, '0);
      chk("R11 pulses", 32'({redir_vld, halt_req, bad_code, sr_wr, dslot_clear}), 32'd0);
      chk("R11 words", redir_pc | sr_next | halt_pc, '0);
      rst_n = 1'b1;
      @(negedge clk);

      // sweep every code x delay slot x vector base, each followed by a return
      for (int code = 0; code < 32; code++) begin
         for (int ds = 0; ds < 2; ds++) begin
            for (int hv = 0; hv < 2; hv++) begin
               logic [XLEN-1:0] pc, sr;
               pc = 32'h0000_2000 + 32'(code) * 32'h40 + 32'(ds) * 8 + 32'(hv) * 4;
               sr = (32'h8000_0001 ^ (32'(code * 4 + ds * 2 + hv) * 32'h0101_0101));
               sr[14] = hv[0];
               sr[13] = ~ds[0];
               apply(1, 0, code, pc, ds[0], sr);
               apply(0, 1, 0, 32'h0, 0, 32'h0);
            end
         end
      end
      idle_check();

      // R2 wrap at address zero in a delay slot
      apply(1, 0, 2, 32'h0000_0000, 1, 32'h0000_0000);
      chk("R2 wrap low", epc_q, 32'hFFFF_FFFC);
      // R1 wrap at the top of the address space
      apply(1, 0, 12, 32'hFFFF_FFFC, 0, 32'h0000_4000);
      chk("R1 wrap high", epc_q, 32'h0000_0000);
      // R3: reset code keeps epc from the previous entry
      apply(1, 0, 1, 32'h1234_5678, 1, 32'h0000_0000);
      chk("R3 epc kept", epc_q, 32'h0000_0000);
      // R10: exception beats simultaneous return
      apply(1, 1, 13, 32'h0000_8000, 0, 32'h0000_0000);
      chk("R10 priority redir", redir_pc, 32'h0000_0D00);
      // R6: trap leaves saved state untouched, then return still uses old state
      apply(1, 0, 14, 32'hABCD_0000, 1, 32'hFFFF_FFFF);
      apply(0, 1, 0, 32'h0, 0, 32'h0);
      chk("R7 return after trap", redir_pc, 32'h0000_8004);
      idle_check();

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule